// File: doc/BRIEF.md
# Secure-Lockout Recovery Test Port

This block is a four-wire test access port with an extra route to unlock a device whose flash is read-protected. A debugger first loads the recovery opcode into the instruction register. It then shifts a 7-bit divide ratio into the recovery data register and parks the port state machine in Run-Test/Idle. If the device is secured and the ratio is nonzero, an erase sequencer starts to walk every physical flash block. The last index is the configuration field, which holds the security setting. The sequencer talks to the flash controller over a four-phase request/acknowledge pair and is paced by a step enable derived from TCK.

When the walk finishes, a sticky completion flag is set. The debugger can read it back through the recovery data register. The security flag is sampled from the configuration field only while the system reset is applied, so protection drops on the first system reset after a full erase. Leaving Run-Test/Idle early abandons the walk. A device that is not secured ignores the recovery opcode. Every other opcode selects the one-bit bypass path, whether or not the device is secured.

Top module: `lockout_recovery_tap`

## Requirements
- R1: `trst_n` low at a TCK rising edge puts the port in Test-Logic-Reset. Five TCK edges with `tms` high also reach Test-Logic-Reset from any state. Test-Logic-Reset loads the bypass opcode 4'hF into the instruction register.
- R2: The instruction register is 4 bits wide and shifts LSB first. It captures 4'b0001 in Capture-IR. Any opcode other than 4'h5 selects a 1-bit bypass register, which captures 0 and delays `tdi` by one shift to `tdo`.
- R3: Opcode 4'h5 selects a 7-bit recovery register that shifts LSB first. In Capture-DR it loads the completion flag into bit 0 and zero into bits 6..1. Update-DR latches the shifted value as the divide ratio.
- R4: An erase starts only on the first Run-Test/Idle cycle after a recovery Update-DR, and only with the device secured and a nonzero ratio. A ratio of 0 never starts an erase.
- R5: The sequencer advances only on a step enable that fires once every (ratio+1) TCK cycles. With an acknowledge that follows a request within one cycle, successive block requests rise 2*(ratio+1) cycles apart.
- R6: The sequencer requests blocks 0 to NUM_BLK-1 in increasing order. For each block it holds `erase_req` until `erase_ack` is high, then waits for `erase_ack` to go low. After the last block (the configuration field) it sets `erase_done`, which stays set until the next system reset.
- R7: Leaving Run-Test/Idle during an erase drops `erase_req` within one cycle. An aborted erase leaves `erase_done` clear and never resumes without a new Update-DR, so the configuration field is not erased and `secured` stays set after a system reset.
- R8: With `secured` low, the recovery opcode causes no erase request and leaves `erase_done` clear.
- R9: `secured` loads `secure_cfg` while `sys_rst_n` is low and holds otherwise. `erase_done` is cleared by `sys_rst_n` and not by `trst_n`.
- R10: The bypass path works while `secured` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all state changes on its rising edge |
| trst_n | input | 1 | Synchronous active-low port reset |
| sys_rst_n | input | 1 | Synchronous active-low system reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, from the selected shift register in a shift state |
| secure_cfg | input | 1 | Security bit read from the flash configuration field |
| secured | output | 1 | Device security flag |
| erase_req | output | 1 | Block erase request to the flash controller |
| erase_blk | output | 2 | Index of the block being erased (NUM_BLK-1 is the configuration field) |
| erase_ack | input | 1 | Block erase acknowledge from the flash controller |
| erase_done | output | 1 | Sticky flag: full erase finished |

## Verification
The assertions assume that `erase_ack` behaves as a four-phase partner: it rises only while a request is up and falls only after the request drops. They also assume that `secure_cfg` is stable around a system reset. The bench's flash stub registers its acknowledge from the request one cycle later and clears its stored security bit when it acknowledges the configuration block. Stimulus reprograms that bit only while the system is out of reset and no erase is running. Every divide ratio used is at least 1 whenever an erase is expected, so the acknowledge always arrives before the next step enable.

// File: rtl/lr_pkg.sv
// Shared types for the lockout recovery port.
// Assumes: nothing; declarations only.
package lr_pkg;
    typedef enum logic [3:0] {
        S_TLR, S_RTI, S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PAU_DR, S_EX2_DR,
        S_UPD_DR, S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PAU_IR, S_EX2_IR, S_UPD_IR
    } tap_state_t;

    typedef enum logic [1:0] {
        SQ_IDLE, SQ_REQ, SQ_GAP
    } seq_state_t;
endpackage

// File: rtl/lr_tap_fsm.sv
// Sixteen-state test port controller clocked by TCK.
// Assumes: trst_n is synchronous to tck and active low.
module lr_tap_fsm
    import lr_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_t state
);
    tap_state_t nxt;

    // Next-state decode from the current state and TMS.
    always_comb begin
        unique case (state)
            S_TLR:    nxt = tms ? S_TLR    : S_RTI;
            S_RTI:    nxt = tms ? S_SEL_DR : S_RTI;
            S_SEL_DR: nxt = tms ? S_SEL_IR : S_CAP_DR;
            S_CAP_DR: nxt = tms ? S_EX1_DR : S_SH_DR;
            S_SH_DR:  nxt = tms ? S_EX1_DR : S_SH_DR;
            S_EX1_DR: nxt = tms ? S_UPD_DR : S_PAU_DR;
            S_PAU_DR: nxt = tms ? S_EX2_DR : S_PAU_DR;
            S_EX2_DR: nxt = tms ? S_UPD_DR : S_SH_DR;
            S_UPD_DR: nxt = tms ? S_SEL_DR : S_RTI;
            S_SEL_IR: nxt = tms ? S_TLR    : S_CAP_IR;
            S_CAP_IR: nxt = tms ? S_EX1_IR : S_SH_IR;
            S_SH_IR:  nxt = tms ? S_EX1_IR : S_SH_IR;
            S_EX1_IR: nxt = tms ? S_UPD_IR : S_PAU_IR;
            S_PAU_IR: nxt = tms ? S_EX2_IR : S_PAU_IR;
            S_EX2_IR: nxt = tms ? S_UPD_IR : S_SH_IR;
            S_UPD_IR: nxt = tms ? S_SEL_DR : S_RTI;
            default:  nxt = S_TLR;
        endcase
    end

    // State register with synchronous port reset.
    always_ff @(posedge tck) begin
        if (!trst_n) state <= S_TLR;
        else         state <= nxt;
    end

    AST_TRST_TO_TLR: assert property (@(posedge tck) !trst_n |=> state == S_TLR); // R1
endmodule

// File: rtl/lr_erase_seq.sv
// Erase sequencer: paces a walk over all flash blocks with a divided step
// enable and a four-phase request/acknowledge per block.
// Assumes: start is a single-cycle pulse only while idle; in_rti is the
// port's Run-Test/Idle indication; erase_ack obeys four-phase rules.
module lr_erase_seq
    import lr_pkg::*;
#(
    parameter  int DIV_W   = 7,
    parameter  int NUM_BLK = 4,
    localparam int BLK_W   = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             in_rti,
    input  logic [DIV_W-1:0] ratio,
    input  logic             erase_ack,
    output logic             erase_req,
    output logic [BLK_W-1:0] erase_blk,
    output logic             busy,
    output logic             done_pulse
);
    seq_state_t       st;
    logic [DIV_W-1:0] cnt;
    logic             tick;
    logic             last;

    // Step enable and last-block decode.
    always_comb begin
        tick = (cnt == ratio);
        last = (erase_blk == BLK_W'(NUM_BLK - 1));
    end

    // Outputs derived from the sequencer state.
    always_comb begin
        erase_req  = (st == SQ_REQ);
        busy       = (st != SQ_IDLE);
        done_pulse = (st == SQ_GAP) && in_rti && tick && !erase_ack && last;
    end

    // Walk the blocks; abandon the walk when the port leaves Run-Test/Idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= SQ_IDLE;
            erase_blk <= '0;
            cnt       <= '0;
        end else if (start) begin
            st        <= SQ_REQ;
            erase_blk <= '0;
            cnt       <= '0;
        end else if (busy && !in_rti) begin
            st <= SQ_IDLE;
        end else if (busy) begin
            cnt <= tick ? '0 : cnt + DIV_W'(1);
            if (tick) begin
                case (st)
                    SQ_REQ: if (erase_ack) st <= SQ_GAP;
                    SQ_GAP: if (!erase_ack) begin
                        if (last) st <= SQ_IDLE;
                        else begin
                            erase_blk <= erase_blk + BLK_W'(1);
                            st        <= SQ_REQ;
                        end
                    end
                    default: st <= SQ_IDLE;
                endcase
            end
        end
    end

    AST_REQ_HOLD:    assert property (@(posedge clk) disable iff (!rst_n)
                         erase_req && !erase_ack && in_rti && !start |=> erase_req); // R6
    AST_ABORT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
                         busy && !in_rti && !start |=> !erase_req); // R7
    AST_BLK_RANGE:   assert property (@(posedge clk) disable iff (!rst_n)
                         erase_req |-> erase_blk <= BLK_W'(NUM_BLK - 1)); // R6
endmodule

// File: rtl/lockout_recovery_tap.sv
// Test port with instruction/data chains, bypass path, lockout recovery
// register and the security flag. Drives the erase sequencer.
// Assumes: one clock (tck); secure_cfg reflects the flash configuration
// field and is stable while sys_rst_n is low.
module lockout_recovery_tap
    import lr_pkg::*;
#(
    parameter  int          IR_W       = 4,
    parameter  int          DIV_W      = 7,
    parameter  int          NUM_BLK    = 4,
    parameter  logic [3:0]  OP_RECOVER = 4'h5,
    localparam int          BLK_W      = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             sys_rst_n,
    input  logic             tms,
    input  logic             tdi,
    output logic             tdo,
    input  logic             secure_cfg,
    output logic             secured,
    output logic             erase_req,
    output logic [BLK_W-1:0] erase_blk,
    input  logic             erase_ack,
    output logic             erase_done
);
    localparam logic [IR_W-1:0] OP_BYPASS = '1;

    tap_state_t       state;
    logic [IR_W-1:0]  ir_sh, ir_q;
    logic [DIV_W-1:0] rec_sh, ratio_q;
    logic             byp_q, armed, sel_rec, start, busy, done_pulse, seq_rst_n;

    lr_tap_fsm u_fsm (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .state  (state)
    );

    // Instruction decode and start qualification.
    always_comb begin
        sel_rec   = (ir_q == IR_W'(OP_RECOVER));
        start     = armed && (state == S_RTI) && sel_rec && secured
                    && (ratio_q != '0) && !busy;
        seq_rst_n = trst_n && sys_rst_n;
    end

    // Instruction shift chain and active instruction.
    always_ff @(posedge tck) begin
        if (!trst_n || state == S_TLR) begin
            ir_sh <= '0;
            ir_q  <= OP_BYPASS;
        end else begin
            case (state)
                S_CAP_IR: ir_sh <= IR_W'(1);
                S_SH_IR:  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
                S_UPD_IR: ir_q  <= ir_sh;
                default:  ;
            endcase
        end
    end

    // Data chains: bypass bit, recovery register, ratio and arming.
    always_ff @(posedge tck) begin
        if (!trst_n) begin
            byp_q   <= 1'b0;
            rec_sh  <= '0;
            ratio_q <= '0;
            armed   <= 1'b0;
        end else begin
            case (state)
                S_CAP_DR: begin
                    byp_q  <= 1'b0;
                    rec_sh <= {{(DIV_W-1){1'b0}}, erase_done};
                end
                S_SH_DR: begin
                    if (sel_rec) rec_sh <= {tdi, rec_sh[DIV_W-1:1]};
                    else         byp_q  <= tdi;
                end
                S_UPD_DR: if (sel_rec) begin
                    ratio_q <= rec_sh;
                    armed   <= 1'b1;
                end
                S_RTI, S_TLR: armed <= 1'b0;
                default: ;
            endcase
        end
    end

    // Serial output selection.
    always_comb begin
        case (state)
            S_SH_IR: tdo = ir_sh[0];
            S_SH_DR: tdo = sel_rec ? rec_sh[0] : byp_q;
            default: tdo = 1'b0;
        endcase
    end

    // Security flag sampled at system reset; sticky completion flag.
    always_ff @(posedge tck) begin
        if (!sys_rst_n) begin
            secured    <= secure_cfg;
            erase_done <= 1'b0;
        end else if (done_pulse) begin
            erase_done <= 1'b1;
        end
    end

    lr_erase_seq #(.DIV_W(DIV_W), .NUM_BLK(NUM_BLK)) u_seq (
        .clk        (tck),
        .rst_n      (seq_rst_n),
        .start      (start),
        .in_rti     (state == S_RTI),
        .ratio      (ratio_q),
        .erase_ack  (erase_ack),
        .erase_req  (erase_req),
        .erase_blk  (erase_blk),
        .busy       (busy),
        .done_pulse (done_pulse)
    );

    AST_REQ_SECURED: assert property (@(posedge tck) disable iff (!seq_rst_n)
                         erase_req |-> secured); // R8
    AST_DONE_STICKY: assert property (@(posedge tck) disable iff (!sys_rst_n)
                         erase_done |=> erase_done); // R6
    AST_NO_ZERO_RUN: assert property (@(posedge tck) disable iff (!seq_rst_n)
                         $rose(erase_req) |-> ratio_q != '0); // R4
endmodule

// File: tb/lockout_recovery_tap_test.sv
module lockout_recovery_tap_test;
    localparam int TCK_PERIOD = 10;
    localparam int NBLK = 4;

    logic tck = 1'b0, trst_n = 1'b0, sys_rst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
    logic tdo, secured, erase_req, erase_ack = 1'b0, erase_done;
    logic [1:0] erase_blk;
    logic flash_sec = 1'b1, prog_req = 1'b0;

    int checks = 0, fails = 0, cyc = 0;
    bit finished = 0, seen_rise = 0;
    logic last_tdo = 1'b0, req_d = 1'b0;
    int exp_q[$];
    int rise_q[$];

    lockout_recovery_tap uut (
        .tck(tck), .trst_n(trst_n), .sys_rst_n(sys_rst_n), .tms(tms), .tdi(tdi),
        .tdo(tdo), .secure_cfg(flash_sec), .secured(secured), .erase_req(erase_req),
        .erase_blk(erase_blk), .erase_ack(erase_ack), .erase_done(erase_done)
    );

    always #(TCK_PERIOD/2) tck = ~tck;
    always @(posedge tck) cyc <= cyc + 1;

    // Flash stub: acknowledge one cycle after request; wiping the config block clears security.
    always @(posedge tck) begin
        erase_ack <= erase_req;
        if (prog_req) flash_sec <= 1'b1;
        else if (erase_req && !erase_ack && erase_blk == 2'(NBLK - 1)) flash_sec <= 1'b0;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: pop expected block on each request rise.
    always @(negedge tck) begin
        if (erase_req && !req_d) begin
            seen_rise = 1;
            rise_q.push_back(cyc);
            if (exp_q.size() == 0) check(0, "R8/R7 unexpected request", erase_blk, -1);
            else begin
                int e;
                e = exp_q.pop_front();
                check(erase_blk == 2'(e), "R6 block order", erase_blk, e);
            end
        end
        req_d = erase_req;
    end

    task automatic step(input logic m, input logic d);
        @(negedge tck);
        last_tdo = tdo;
        tms = m; tdi = d;
        @(posedge tck);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0);
    endtask

    task automatic shift_ir(input logic [3:0] v, output logic [3:0] o);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 4; i++) begin
            step(i == 3, v[i]);
            o[i] = last_tdo;
        end
        step(1, 0); step(0, 0);
    endtask

    task automatic shift_dr(input int n, input logic [7:0] v, output logic [7:0] o);
        o = '0;
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, v[i]);
            o[i] = last_tdo;
        end
        step(1, 0); step(0, 0);
    endtask

    task automatic sys_reset();
        @(negedge tck) sys_rst_n = 1'b0;
        repeat (2) @(posedge tck);
        @(negedge tck) sys_rst_n = 1'b1;
    endtask

    task automatic full_erase(input logic [6:0] ratio);
        logic [3:0] io;
        logic [7:0] dout;
        for (int b = 0; b < NBLK; b++) exp_q.push_back(b);
        rise_q.delete();
        shift_ir(4'h5, io);
        shift_dr(7, {1'b0, ratio}, dout);
        idle(20 * (int'(ratio) + 1) + 10);
        check(rise_q.size() == NBLK, "R6 request count", rise_q.size(), NBLK);
        for (int i = 1; i < rise_q.size(); i++)
            check(rise_q[i] - rise_q[i-1] == 2 * (int'(ratio) + 1), "R5 step spacing",
                  rise_q[i] - rise_q[i-1], 2 * (int'(ratio) + 1));
        check(erase_done == 1'b1, "R6 done set", erase_done, 1);
    endtask

    initial begin
        logic [3:0] io;
        logic [7:0] dout;
        repeat (3) @(posedge tck);
        @(negedge tck) begin trst_n = 1'b1; sys_rst_n = 1'b1; end
        check(secured == 1'b1, "R9 secured from config", secured, 1);
        check(erase_done == 1'b0 && erase_req == 1'b0, "R9 reset state", erase_done, 0);
        check(tdo == 1'b0, "R1 tdo idle", tdo, 0);

        // R1: load recovery opcode, then five TMS-high edges return to bypass.
        step(0, 0);
        shift_ir(4'h5, io);
        check(io == 4'b0001, "R2 IR capture", io, 1);
        repeat (5) step(1, 0);
        step(0, 0);
        shift_dr(8, 8'hA5, dout);
        check(dout == 8'h4A, "R1/R10 bypass after TMS reset", dout, 8'h4A);

        // R2: unknown opcode selects bypass (R10 while secured).
        shift_ir(4'h3, io);
        shift_dr(8, 8'h3C, dout);
        check(dout == 8'h78, "R2 unknown opcode bypass", dout, 8'h78);

        // R4: zero ratio never starts; R3 capture shows done=0.
        shift_ir(4'h5, io);
        shift_dr(7, 8'h00, dout);
        check(dout[0] == 1'b0, "R3 capture done=0", dout[0], 0);
        idle(30);
        check(erase_req == 1'b0 && erase_done == 1'b0, "R4 zero ratio idle", erase_done, 0);

        // R5/R6: full erase with ratio 3.
        full_erase(7'd3);
        check(secured == 1'b1, "R9 secured holds until reset", secured, 1);
        shift_ir(4'h5, io);
        shift_dr(7, 8'h00, dout);
        check(dout[0] == 1'b1, "R3 capture done=1", dout[0], 1);

        // R9: port reset keeps the done flag.
        @(negedge tck) trst_n = 1'b0;
        repeat (2) @(posedge tck);
        @(negedge tck) trst_n = 1'b1;
        step(0, 0);
        shift_ir(4'h5, io);
        shift_dr(7, 8'h00, dout);
        check(dout[0] == 1'b1, "R9 done survives trst", dout[0], 1);

        // R9/R6: system reset drops security after the full erase.
        sys_reset();
        check(secured == 1'b0, "R6 security cleared", secured, 0);
        check(erase_done == 1'b0, "R9 done cleared by sys reset", erase_done, 1'b0);

        // R8: unsecured device ignores recovery.
        shift_ir(4'h5, io);
        shift_dr(7, 8'h03, dout);
        idle(40);
        check(erase_done == 1'b0 && erase_req == 1'b0, "R8 no effect unsecured", erase_done, 0);

        // R7: abort by leaving Run-Test/Idle.
        @(negedge tck) prog_req = 1'b1;
        @(negedge tck) prog_req = 1'b0;
        sys_reset();
        check(secured == 1'b1, "R9 re-secured", secured, 1);
        exp_q.push_back(0);
        seen_rise = 0;
        shift_ir(4'h5, io);
        shift_dr(7, 8'h03, dout);
        for (int i = 0; i < 10 && !seen_rise; i++) step(0, 0);
        idle(2);
        step(1, 0); step(1, 0); step(1, 0);
        @(negedge tck);
        check(erase_req == 1'b0, "R7 request dropped", erase_req, 0);
        step(0, 0);
        idle(30);
        check(erase_done == 1'b0, "R7 no done after abort", erase_done, 0);
        sys_reset();
        check(secured == 1'b1, "R7 still secured", secured, 1);

        // R5: full erase with ratio 1.
        full_erase(7'd1);
        check(exp_q.size() == 0, "R6 all blocks seen", exp_q.size(), 0);

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge tck);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule